// File: doc/BRIEF.md
# Ethernet MAC Learning Forwarding Table

This block picks the egress ports for every frame in a four-port switch. Each received frame supplies its source MAC address and ingress port through a learn strobe. The table stores that pairing, so frames addressed to that station later go to that port only. A lookup strobe supplies a destination MAC address and the ingress port. Two clock cycles later the block returns a port mask with a valid strobe. The mask has one bit for each of the four external ports and one more bit for the on-chip CPU port.

The table has a fixed number of entries. Each entry has its own age counter, which a shared time tick advances. An entry that is not refreshed before its counter reaches the limit disappears. When a new address arrives and every entry is in use, the entry that was first learned earliest is replaced. A destination that is unknown, or that has the group bit set (this includes broadcast), is flooded to every external port except the ingress port. A single unicast address belongs to the CPU: it always maps to the CPU port, and it is never learned or aged.

Top module: `mac_fwd_table`

## Requirements
- R1: After a learn of (MAC, port p), a lookup of that MAC returns a mask with only bit p set (bits 0..3 are external ports 0..3, bit 4 is the CPU port).
- R2: Learning a MAC that is already stored moves it to the new port and reuses its entry, so the number of occupied entries does not grow.
- R3: A lookup of an unknown unicast MAC returns bits 0..3 set except the ingress port's bit, with bit 4 clear.
- R4: A destination whose group bit is set (bit 40 of the 48-bit value, i.e. bit 0 of the first octet; all-ones included) is flooded as in R3.
- R5: A lookup of the CPU address (default 02:00:00:00:00:01) returns only bit 4. A learn of that address has no effect and takes no entry.
- R6: With all 16 entries occupied, learning a new MAC replaces the entry whose first learn is the earliest, and every other entry stays.
- R7: A refresh of an existing entry does not change its place in the replacement order.
- R8: Each age tick advances every stored entry. An entry that goes AGE_LIMIT ticks (default 255) without a learn of its MAC becomes invalid. After AGE_LIMIT-1 ticks it is still present.
- R9: A learn of a stored MAC restarts its age count from zero.
- R10: fwd_valid rises exactly two clock edges after the edge that samples lkp_valid. A lookup sampled on the same edge as a learn sees the table without that learn.
- R11: In reset and right after it, fwd_valid is low, the mask is zero and the table is empty.
- R12: A new MAC fills a free entry (one left invalid by ageing) before any occupied entry is replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| learn_valid | input | 1 | Learn strobe, one cycle per received frame |
| learn_mac | input | 48 | Source MAC address to learn |
| learn_port | input | PORT_W (2) | Ingress port of the learned frame |
| age_tick | input | 1 | Time tick that advances all age counters |
| lkp_valid | input | 1 | Lookup strobe |
| lkp_mac | input | 48 | Destination MAC address to look up |
| lkp_port | input | PORT_W (2) | Ingress port of the frame being forwarded |
| fwd_valid | output | 1 | Mask valid, two cycles after lkp_valid |
| fwd_mask | output | N_PORTS+1 (5) | Egress mask, bit 4 is the CPU port |

## Verification
The bench fills the table to 16 entries, refreshes the oldest entry, and then learns a new address. A design that orders entries by last use would evict the wrong entry. A design that creates duplicates would lose a still-live address. It checks the age boundary one tick before the limit and exactly at it, which catches off-by-one expiry. It also checks a refresh midway through the count: a design that does not clear the counter would expire the entry early. Other tests cover a learn and a lookup on the same edge, where a design that forwards the new entry returns a hit instead of a flood. They also cover addresses left free by ageing, where a design that always evicts would push out live entries. Finally, they cover the CPU address, where a learn that takes an entry would show up as an early eviction.

// File: rtl/mft_pkg.sv
// Shared constants and types for the MAC forwarding table.
// Assumes 48-bit MAC values with the first octet in bits 47:40.
package mft_pkg;
    localparam int MAC_W     = 48;
    localparam int GROUP_BIT = 40;

    // Lookup classification carried from stage 1 to stage 2.
    typedef enum logic [1:0] {
        CLS_MISS,
        CLS_HIT,
        CLS_CPU,
        CLS_GROUP
    } lkp_class_e;
endpackage

// File: rtl/mft_victim_sel.sv
// Picks the entry that a new address will occupy: the lowest-index free
// entry if one exists, otherwise the entry whose rank is N_ENTRIES-1.
// Assumes ranks of valid entries form a permutation when the table is full.
module mft_victim_sel #(
    parameter int N_ENTRIES = 16
) (
    input  logic [N_ENTRIES-1:0]         ent_valid,
    input  logic [$clog2(N_ENTRIES)-1:0] ent_rank [N_ENTRIES],
    output logic [$clog2(N_ENTRIES)-1:0] victim_idx
);
    localparam int IDX_W = $clog2(N_ENTRIES);

    // Free entry takes precedence over the oldest occupied entry.
    always_comb begin
        victim_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (ent_rank[i] == IDX_W'(N_ENTRIES - 1)) victim_idx = IDX_W'(i);
        end
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) victim_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/mft_table.sv
// Entry storage with learning, ageing and insertion-order ranks.
// Rank of an entry = number of valid entries inserted after it, so the
// oldest has rank N_ENTRIES-1 when full. Refresh keeps the rank.
// Assumes AGE_LIMIT >= 1 and AGE_LIMIT < 2**AGE_W.
module mft_table #(
    parameter int          N_ENTRIES = 16,
    parameter int          PORT_W    = 2,
    parameter int          AGE_W     = 8,
    parameter int          AGE_LIMIT = 255,
    parameter logic [47:0] CPU_MAC   = 48'h02_00_00_00_00_01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 learn_valid,
    input  logic [47:0]          learn_mac,
    input  logic [PORT_W-1:0]    learn_port,
    input  logic                 age_tick,
    output logic [N_ENTRIES-1:0] ent_valid,
    output logic [47:0]          ent_mac  [N_ENTRIES],
    output logic [PORT_W-1:0]    ent_port [N_ENTRIES]
);
    localparam int IDX_W = $clog2(N_ENTRIES);

    logic [AGE_W-1:0]     ent_age  [N_ENTRIES];
    logic [IDX_W-1:0]     ent_rank [N_ENTRIES];
    logic [IDX_W-1:0]     dec      [N_ENTRIES];
    logic [N_ENTRIES-1:0] hit_vec;
    logic [N_ENTRIES-1:0] expire;
    logic [IDX_W-1:0]     hit_idx;
    logic [IDX_W-1:0]     victim_idx;
    logic [IDX_W-1:0]     tgt_idx;
    logic                 learn_ok;
    logic                 any_hit;
    logic                 do_ins;

    mft_victim_sel #(.N_ENTRIES(N_ENTRIES)) i_victim (
        .ent_valid  (ent_valid),
        .ent_rank   (ent_rank),
        .victim_idx (victim_idx)
    );

    // Match the learn address against stored entries.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            hit_vec[i] = ent_valid[i] && (ent_mac[i] == learn_mac);
        end
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign learn_ok = learn_valid && (learn_mac != CPU_MAC);
    assign any_hit  = |hit_vec;
    assign do_ins   = learn_ok && !any_hit;
    assign tgt_idx  = any_hit ? hit_idx : victim_idx;

    // Entries that reach the age limit on this tick, unless just learned.
    always_comb begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            expire[i] = age_tick && ent_valid[i]
                        && (ent_age[i] == AGE_W'(AGE_LIMIT - 1))
                        && !(learn_ok && (tgt_idx == IDX_W'(i)));
        end
    end

    // Count expiring entries that are younger than each entry.
    always_comb begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            dec[i] = '0;
            for (int j = 0; j < N_ENTRIES; j++) begin
                if (expire[j] && (ent_rank[j] < ent_rank[i])) dec[i] = dec[i] + 1'b1;
            end
        end
    end

    // Update every entry: learn target, expiry, or ageing and rank shift.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (!rst_n) begin
                ent_valid[i] <= 1'b0;
                ent_mac[i]   <= '0;
                ent_port[i]  <= '0;
                ent_age[i]   <= '0;
                ent_rank[i]  <= '0;
            end else if (learn_ok && (tgt_idx == IDX_W'(i))) begin
                ent_valid[i] <= 1'b1;
                ent_mac[i]   <= learn_mac;
                ent_port[i]  <= learn_port;
                ent_age[i]   <= '0;
                ent_rank[i]  <= do_ins ? '0 : ent_rank[i] - dec[i];
            end else if (expire[i]) begin
                ent_valid[i] <= 1'b0;
            end else if (ent_valid[i]) begin
                if (age_tick) ent_age[i] <= ent_age[i] + 1'b1;
                ent_rank[i] <= ent_rank[i] - dec[i] + IDX_W'(do_ins);
            end
        end
    end
endmodule

// File: rtl/mft_lookup.sv
// Two-stage lookup: stage 1 classifies the destination against the table
// as it stands before this edge's update; stage 2 forms the port mask.
// Assumes the CPU address is unicast and ingress ports are < N_PORTS.
module mft_lookup #(
    parameter int          N_ENTRIES = 16,
    parameter int          N_PORTS   = 4,
    parameter int          PORT_W    = 2,
    parameter logic [47:0] CPU_MAC   = 48'h02_00_00_00_00_01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lkp_valid,
    input  logic [47:0]          lkp_mac,
    input  logic [PORT_W-1:0]    lkp_port,
    input  logic [N_ENTRIES-1:0] ent_valid,
    input  logic [47:0]          ent_mac  [N_ENTRIES],
    input  logic [PORT_W-1:0]    ent_port [N_ENTRIES],
    output logic                 fwd_valid,
    output logic [N_PORTS:0]     fwd_mask
);
    import mft_pkg::*;

    lkp_class_e        cls;
    logic [PORT_W-1:0] hit_port;
    lkp_class_e        s1_cls;
    logic [PORT_W-1:0] s1_hit_port;
    logic [PORT_W-1:0] s1_in_port;
    logic              s1_valid;
    logic [N_PORTS:0]  nxt_mask;

    // Classify the destination: CPU, group, learned hit or miss.
    always_comb begin
        cls      = CLS_MISS;
        hit_port = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (ent_valid[i] && (ent_mac[i] == lkp_mac)) begin
                cls      = CLS_HIT;
                hit_port = ent_port[i];
            end
        end
        if (lkp_mac[GROUP_BIT]) cls = CLS_GROUP;
        if (lkp_mac == CPU_MAC) cls = CLS_CPU;
    end

    // Stage 1 register of the classification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid    <= 1'b0;
            s1_cls      <= CLS_MISS;
            s1_hit_port <= '0;
            s1_in_port  <= '0;
        end else begin
            s1_valid    <= lkp_valid;
            s1_cls      <= cls;
            s1_hit_port <= hit_port;
            s1_in_port  <= lkp_port;
        end
    end

    // Build the egress mask from the class.
    always_comb begin
        nxt_mask = '0;
        case (s1_cls)
            CLS_CPU: nxt_mask[N_PORTS] = 1'b1;
            CLS_HIT: nxt_mask[s1_hit_port] = 1'b1;
            default: begin
                for (int p = 0; p < N_PORTS; p++) begin
                    nxt_mask[p] = (PORT_W'(p) != s1_in_port);
                end
            end
        endcase
    end

    // Stage 2 output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_mask  <= '0;
        end else begin
            fwd_valid <= s1_valid;
            fwd_mask  <= s1_valid ? nxt_mask : '0;
        end
    end
endmodule

// File: rtl/mac_fwd_table.sv
// Top of the MAC learning forwarding table: storage with ageing and
// oldest-first replacement, plus a two-cycle lookup returning an egress
// mask (bits 0..N_PORTS-1 external, bit N_PORTS the CPU port).
// Assumes at most one learn and one lookup per cycle.
module mac_fwd_table #(
    parameter int          N_ENTRIES = 16,
    parameter int          N_PORTS   = 4,
    parameter int          AGE_W     = 8,
    parameter int          AGE_LIMIT = 255,
    parameter logic [47:0] CPU_MAC   = 48'h02_00_00_00_00_01,
    localparam int         PORT_W    = $clog2(N_PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              learn_valid,
    input  logic [47:0]       learn_mac,
    input  logic [PORT_W-1:0] learn_port,
    input  logic              age_tick,
    input  logic              lkp_valid,
    input  logic [47:0]       lkp_mac,
    input  logic [PORT_W-1:0] lkp_port,
    output logic              fwd_valid,
    output logic [N_PORTS:0]  fwd_mask
);
    logic [N_ENTRIES-1:0] ent_valid;
    logic [47:0]          ent_mac  [N_ENTRIES];
    logic [PORT_W-1:0]    ent_port [N_ENTRIES];

    mft_table #(
        .N_ENTRIES (N_ENTRIES),
        .PORT_W    (PORT_W),
        .AGE_W     (AGE_W),
        .AGE_LIMIT (AGE_LIMIT),
        .CPU_MAC   (CPU_MAC)
    ) i_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .learn_valid (learn_valid),
        .learn_mac   (learn_mac),
        .learn_port  (learn_port),
        .age_tick    (age_tick),
        .ent_valid   (ent_valid),
        .ent_mac     (ent_mac),
        .ent_port    (ent_port)
    );

    mft_lookup #(
        .N_ENTRIES (N_ENTRIES),
        .N_PORTS   (N_PORTS),
        .PORT_W    (PORT_W),
        .CPU_MAC   (CPU_MAC)
    ) i_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .lkp_valid (lkp_valid),
        .lkp_mac   (lkp_mac),
        .lkp_port  (lkp_port),
        .ent_valid (ent_valid),
        .ent_mac   (ent_mac),
        .ent_port  (ent_port),
        .fwd_valid (fwd_valid),
        .fwd_mask  (fwd_mask)
    );
endmodule

// File: rtl/mft_checker.sv
// Port-level properties of mac_fwd_table, attached by bind.
module mft_checker #(
    parameter int          N_PORTS = 4,
    parameter int          PORT_W  = 2,
    parameter logic [47:0] CPU_MAC = 48'h02_00_00_00_00_01
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lkp_valid,
    input logic [47:0]       lkp_mac,
    input logic [PORT_W-1:0] lkp_port,
    input logic              fwd_valid,
    input logic [N_PORTS:0]  fwd_mask
);
    localparam logic [N_PORTS:0] CPU_ONLY = (N_PORTS + 1)'(1) << N_PORTS;

    AST_LKP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> ##1 fwd_valid);  // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(lkp_valid, 2));  // R10
    AST_CPU_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && lkp_mac == CPU_MAC) |=> ##1 (fwd_mask == CPU_ONLY));  // R5
    AST_GROUP_FLOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && lkp_mac[40]) |=> ##1
        ($countones(fwd_mask) == N_PORTS - 1 && !fwd_mask[N_PORTS]));  // R4
    AST_FLOOD_NO_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && $countones(fwd_mask) > 1) |-> !fwd_mask[$past(lkp_port, 2)]);  // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_valid |-> (fwd_mask == '0));  // R11
endmodule

bind mac_fwd_table mft_checker #(
    .N_PORTS (N_PORTS),
    .PORT_W  (PORT_W),
    .CPU_MAC (CPU_MAC)
) i_mft_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .lkp_mac   (lkp_mac),
    .lkp_port  (lkp_port),
    .fwd_valid (fwd_valid),
    .fwd_mask  (fwd_mask)
);

// File: tb/test_mac_fwd_table.sv
// Self-checking bench for mac_fwd_table: a vector table of lookups,
// then directed tests for reset, replacement, ageing and timing.
module test_mac_fwd_table;
    localparam logic [47:0] CPU = 48'h02_00_00_00_00_01;
    localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MC  = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] UNK = 48'h00_AA_BB_CC_DD_EE;
    localparam int NV = 10;
    // {mac, ingress, expected mask}
    localparam logic [54:0] VEC [NV] = '{
        {48'h00_1A_2B_00_00_00, 2'd3, 5'b00001},
        {48'h00_1A_2B_00_00_01, 2'd0, 5'b00010},
        {48'h00_1A_2B_00_00_02, 2'd0, 5'b00100},
        {48'h00_1A_2B_00_00_03, 2'd1, 5'b01000},
        {48'h00_1A_2B_00_00_00, 2'd0, 5'b00001},
        {UNK,                   2'd2, 5'b01011},
        {UNK,                   2'd0, 5'b01110},
        {BC,                    2'd1, 5'b01101},
        {MC,                    2'd3, 5'b00111},
        {CPU,                   2'd2, 5'b10000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        learn_valid = 1'b0;
    logic [47:0] learn_mac = '0;
    logic [1:0]  learn_port = '0;
    logic        age_tick = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [47:0] lkp_mac = '0;
    logic [1:0]  lkp_port = '0;
    logic        fwd_valid;
    logic [4:0]  fwd_mask;

    int n_checks = 0;
    int n_fail   = 0;
    logic [4:0] got;

    mac_fwd_table i_mac_fwd_table (
        .clk(clk), .rst_n(rst_n),
        .learn_valid(learn_valid), .learn_mac(learn_mac), .learn_port(learn_port),
        .age_tick(age_tick),
        .lkp_valid(lkp_valid), .lkp_mac(lkp_mac), .lkp_port(lkp_port),
        .fwd_valid(fwd_valid), .fwd_mask(fwd_mask)
    );

    always #4 clk = ~clk;

    function automatic logic [47:0] mac_a(int i);
        return 48'h00_1A_2B_00_00_00 | 48'(i);
    endfunction

    function automatic logic [4:0] flood(logic [1:0] in);
        logic [4:0] m = 5'b01111;
        m[in] = 1'b0;
        return m;
    endfunction

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic learn(logic [47:0] m, logic [1:0] p);
        @(negedge clk);
        learn_valid = 1'b1; learn_mac = m; learn_port = p;
        @(negedge clk);
        learn_valid = 1'b0;
    endtask

    task automatic tick(int n);
        @(negedge clk);
        age_tick = 1'b1;
        repeat (n) @(negedge clk);
        age_tick = 1'b0;
    endtask

    task automatic lookup(logic [47:0] m, logic [1:0] p, output logic [4:0] mask);
        @(negedge clk);
        lkp_valid = 1'b1; lkp_mac = m; lkp_port = p;
        @(negedge clk);
        lkp_valid = 1'b0;
        @(negedge clk);
        mask = fwd_valid ? fwd_mask : 5'bxxxxx;
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R11: outputs idle during reset, table empty afterwards.
        repeat (3) @(negedge clk);
        check("R11 valid in reset", {4'b0, fwd_valid}, 5'b0);
        check("R11 mask in reset", fwd_mask, 5'b0);
        rst_n = 1'b1;
        lookup(mac_a(0), 2'd0, got);
        check("R11 empty table floods", got, flood(2'd0));

        // R1/R3/R4/R5 vector walk.
        for (int i = 0; i < 4; i++) learn(mac_a(i), 2'(i));
        for (int v = 0; v < NV; v++) begin
            lookup(VEC[v][54:7], VEC[v][6:5], got);
            check($sformatf("R1/R3/R4/R5 vector %0d", v), got, VEC[v][4:0]);
        end

        // R10: same-edge learn and lookup; two-edge latency.
        @(negedge clk);
        learn_valid = 1'b1; learn_mac = mac_a(5); learn_port = 2'd2;
        lkp_valid = 1'b1; lkp_mac = mac_a(5); lkp_port = 2'd0;
        @(negedge clk);
        learn_valid = 1'b0; lkp_valid = 1'b0;
        check("R10 not valid after one edge", {4'b0, fwd_valid}, 5'b0);
        @(negedge clk);
        check("R10 valid after two edges", {4'b0, fwd_valid}, 5'b1);
        check("R10 lookup sees pre-learn table", fwd_mask, flood(2'd0));
        lookup(mac_a(5), 2'd0, got);
        check("R10 learned entry visible after", got, 5'b00100);

        // R2: relearn moves port.
        learn(mac_a(1), 2'd3);
        lookup(mac_a(1), 2'd0, got);
        check("R2 port moved", got, 5'b01000);
        // R5: CPU learn ignored.
        learn(CPU, 2'd1);
        lookup(CPU, 2'd0, got);
        check("R5 CPU after learn attempt", got, 5'b10000);

        // R6/R7/R2/R5: replacement order.
        do_reset();
        for (int i = 0; i < 16; i++) learn(mac_a(i), 2'(i % 4));
        learn(mac_a(0), 2'd0);   // refresh, no new entry
        learn(CPU, 2'd2);        // must not take an entry
        learn(mac_a(16), 2'd1);
        lookup(mac_a(0), 2'd2, got);
        check("R7 refreshed oldest still evicted", got, flood(2'd2));
        lookup(mac_a(1), 2'd0, got);
        check("R6 next entry kept", got, 5'b00010);
        lookup(mac_a(16), 2'd0, got);
        check("R6 new entry present", got, 5'b00010);
        lookup(mac_a(15), 2'd0, got);
        check("R2 R5 youngest kept", got, 5'b01000);
        learn(mac_a(17), 2'd2);
        lookup(mac_a(1), 2'd0, got);
        check("R6 second eviction", got, flood(2'd0));
        lookup(mac_a(2), 2'd0, got);
        check("R6 third oldest kept", got, 5'b00100);

        // R8: age boundary.
        do_reset();
        learn(mac_a(0), 2'd1);
        tick(254);
        lookup(mac_a(0), 2'd0, got);
        check("R8 present at limit-1", got, 5'b00010);
        tick(1);
        lookup(mac_a(0), 2'd0, got);
        check("R8 expired at limit", got, flood(2'd0));

        // R9: refresh restarts age.
        do_reset();
        learn(mac_a(0), 2'd3);
        tick(200);
        learn(mac_a(0), 2'd3);
        tick(100);
        lookup(mac_a(0), 2'd0, got);
        check("R9 refreshed entry alive", got, 5'b01000);
        tick(155);
        lookup(mac_a(0), 2'd0, got);
        check("R9 expires from refresh", got, flood(2'd0));

        // R12: free entries used before eviction.
        do_reset();
        for (int i = 0; i < 8; i++) learn(mac_a(i), 2'd1);
        tick(200);
        for (int i = 8; i < 16; i++) learn(mac_a(i), 2'd2);
        tick(55);
        lookup(mac_a(0), 2'd0, got);
        check("R12 first batch expired", got, flood(2'd0));
        for (int i = 0; i < 8; i++) learn(mac_a(32 + i), 2'd3);
        for (int i = 8; i < 16; i++) begin
            lookup(mac_a(i), 2'd0, got);
            check($sformatf("R12 live entry %0d kept", i), got, 5'b00100);
        end
        lookup(mac_a(39), 2'd0, got);
        check("R12 new entry present", got, 5'b01000);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule